// File: doc/BRIEF.md
# Multi-register increment/decrement unit

This unit computes, in a single clock, the step-by-one updates that a small processor applies to its six 16-bit working registers: A, B, C, D, E and the stack pointer SP. A command names one of six modes and up to two registers. The unit returns the new register values, a write enable for each register and a fresh set of zero, negative and overflow flags. The register file and the carry flag are kept outside the unit, and the unit never changes the carry flag.

The register values arrive on one flat bus, with one slot for each register. The caller pulses `go` together with a mode and two register selectors. One clock later the results, enables and flags appear together for a single cycle. Slots that are not written carry their input value through. There are modes that touch two registers, and an implicit mode that touches three. For these modes the unit follows fixed rules when both selectors name the same register and when a register wraps around.

Top module: `incdec_unit`

## Requirements
- R1: After reset, `reg_out` is zero and `reg_we`, `flag_upd`, `flag_z`, `flag_n` and `flag_v` are all low.
- R2: Results, enables and flags reflect the command sampled with `go` at one rising edge and are visible after that edge. In a cycle following an edge without `go`, `reg_we` and `flag_upd` are low.
- R3: Selector value k from 1 to 6 names slot k-1 of the buses (1=A, 2=B, 3=C, 4=D, 5=E, 6=SP, slot 0 in the least significant W bits). Values 0 and 7 name no register. Mode 0 adds one to `sel_r` and mode 1 subtracts one from it. A written slot gets the stepped value and a raised `reg_we` bit.
- R4: Mode 2 increments both `sel_r` and `sel_s`, and mode 3 decrements both. When the two selectors are equal, that register steps only once.
- R5: Mode 4 increments `sel_r` and decrements `sel_s`. When the two selectors are equal, no register is written, but the flags are set from that register minus one.
- R6: Mode 5 decrements C and increments D and E. Both selectors are ignored in this mode.
- R7: `flag_z` is high only when every affected register's result is zero.
- R8: `flag_n` is the OR of bit W-1 over the results of all affected registers.
- R9: `flag_v` is high when any affected register wraps, either from 0 down to all ones or from all ones up to 0.
- R10: Modes 6 and 7, and commands that name no register, write nothing. In those cases `flag_upd` stays low and all flags read zero.
- R11: `flag_upd` is high exactly when at least one register was affected. Slots that are not written output their input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Command valid this cycle |
| mode | input | 3 | Operation: 0 inc, 1 dec, 2 inc both, 3 dec both, 4 inc/dec, 5 implicit C/D/E |
| sel_r | input | 3 | First register selector |
| sel_s | input | 3 | Second register selector |
| reg_in | input | 6*W | Current register values, slot k-1 for selector k |
| reg_out | output | 6*W | New register values |
| reg_we | output | 6 | Per-slot write enable |
| flag_upd | output | 1 | Flags below are valid and must be written |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench builds the unit with the default width of 16, so the register values it drives are exactly the ones named in the requirements. At that width a test can place values such as 0x0000, 0xFFFF, 0x7FFF and 0x8000 directly in the slots. This makes it possible to hit both wrap directions, the change of sign without a wrap, and cases where the zero flag depends on more than one result. The vectors place equal selectors, unused selector values and unused modes next to ordinary commands, and the commands run back to back so that no state leaks from one to the next.

// File: rtl/incdec_unit.sv
`timescale 1ns/1ps
module incdec_unit #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [2:0]        mode,
  input  logic [2:0]        sel_r,
  input  logic [2:0]        sel_s,
  input  logic [6*W-1:0]    reg_in,
  output logic [6*W-1:0]    reg_out,
  output logic [5:0]        reg_we,
  output logic              flag_upd,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v
);
  localparam int NREG = 6;
  localparam logic [2:0] M_INC   = 3'd0;
  localparam logic [2:0] M_DEC   = 3'd1;
  localparam logic [2:0] M_INCM  = 3'd2;
  localparam logic [2:0] M_DECM  = 3'd3;
  localparam logic [2:0] M_INDEC = 3'd4;
  localparam logic [2:0] M_IMPL  = 3'd5;

  logic [NREG*W-1:0] nx_out;
  logic [NREG-1:0]   nx_we, aff, zero_v, neg_v, ov_v;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [2:0] SEL = 3'(i + 1);
    localparam bit IMPL_DN = (i == 2);
    localparam bit IMPL_UP = (i == 3) || (i == 4);
    logic [W-1:0] cur, upd;
    logic hr, hs, inc, dec, fo;

    assign cur = reg_in[i*W +: W];
    assign hr  = (sel_r == SEL);
    assign hs  = (sel_s == SEL);

    always_comb begin
      inc = 1'b0;
      dec = 1'b0;
      fo  = 1'b0;
      case (mode)
        M_INC:   inc = hr;
        M_DEC:   dec = hr;
        M_INCM:  inc = hr | hs;
        M_DECM:  dec = hr | hs;
        M_INDEC: begin
          inc = hr & ~hs;
          dec = hs & ~hr;
          fo  = hr & hs;
        end
        M_IMPL: begin
          inc = IMPL_UP;
          dec = IMPL_DN;
        end
        default: ;
      endcase
    end

    assign upd       = inc ? cur + W'(1) : cur - W'(1);
    assign aff[i]    = inc | dec | fo;
    assign nx_we[i]  = inc | dec;
    assign zero_v[i] = ~aff[i] | (upd == '0);
    assign neg_v[i]  = aff[i] & upd[W-1];
    assign ov_v[i]   = (inc & (&cur)) | ((dec | fo) & (cur == '0));
    assign nx_out[i*W +: W] = nx_we[i] ? upd : cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_out  <= '0;
      reg_we   <= '0;
      flag_upd <= 1'b0;
      flag_z   <= 1'b0;
      flag_n   <= 1'b0;
      flag_v   <= 1'b0;
    end else if (go) begin
      reg_out  <= nx_out;
      reg_we   <= nx_we;
      flag_upd <= |aff;
      flag_z   <= (|aff) & (&zero_v);
      flag_n   <= |neg_v;
      flag_v   <= |ov_v;
    end else begin
      reg_we   <= '0;
      flag_upd <= 1'b0;
      flag_z   <= 1'b0;
      flag_n   <= 1'b0;
      flag_v   <= 1'b0;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (reg_we == '0) && !flag_upd);

  // R3
  inc_a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && mode == M_INC && sel_r == 3'd1 |=>
      reg_out[W-1:0] == $past(reg_in[W-1:0]) + W'(1));

  // R4
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && (mode == M_INCM || mode == M_DECM) |=> $countones(reg_we) <= 2);

  // R5
  indec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && mode == M_INDEC && sel_r == sel_s |=> reg_we == '0);

  // R6
  impl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && mode == M_IMPL |=> reg_we == 6'b011100 && flag_upd);

  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && mode > M_IMPL |=> reg_we == '0 && !flag_upd);

  // R11
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_z || flag_n || flag_v || reg_we != '0) |-> flag_upd);
endmodule

// File: tb/incdec_unit_test.sv
`timescale 1ns/1ps
module incdec_unit_test;
  localparam int W  = 16;
  localparam int NV = 24;
  localparam logic [95:0] IN0 = 96'h8000_0005_0004_0003_0002_0001;
  localparam logic [95:0] IN1 = 96'hFFFF_0000_0001_0000_FFFF_0000;
  localparam logic [95:0] IN2 = 96'h0000_0000_0000_0000_0000_7FFF;

  localparam logic [2:0] T_MODE [NV] = '{3'd0,3'd1,3'd0,3'd1,3'd2,3'd3,3'd4,3'd4,3'd5,3'd6,3'd0,3'd0,
                                         3'd1,3'd3,3'd2,3'd4,3'd4,3'd5,3'd3,3'd1,3'd0,3'd7,3'd1,3'd2};
  localparam logic [2:0] T_R [NV] = '{3'd1,3'd2,3'd6,3'd6,3'd1,3'd4,3'd4,3'd3,3'd7,3'd1,3'd0,3'd2,
                                      3'd1,3'd4,3'd2,3'd2,3'd3,3'd7,3'd4,3'd4,3'd1,3'd1,3'd7,3'd1};
  localparam logic [2:0] T_S [NV] = '{3'd0,3'd0,3'd0,3'd0,3'd3,3'd4,3'd5,3'd3,3'd7,3'd2,3'd0,3'd0,
                                      3'd0,3'd4,3'd6,3'd1,3'd3,3'd7,3'd1,3'd0,3'd0,3'd1,3'd0,3'd1};
  localparam logic [95:0] T_IN [NV] = '{IN0,IN0,IN0,IN0,IN0,IN0,IN0,IN0,IN0,IN0,IN0,IN1,
                                        IN1,IN1,IN1,IN1,IN1,IN1,IN1,IN1,IN2,IN2,IN2,IN2};
  // per slot SP..A: 01 step up, 10 step down, 00 untouched
  localparam logic [11:0] T_DEL [NV] = '{
    12'b00_00_00_00_00_01, 12'b00_00_00_00_10_00, 12'b01_00_00_00_00_00, 12'b10_00_00_00_00_00,
    12'b00_00_00_01_00_01, 12'b00_00_10_00_00_00, 12'b00_10_01_00_00_00, 12'b00_00_00_00_00_00,
    12'b00_01_01_10_00_00, 12'b00_00_00_00_00_00, 12'b00_00_00_00_00_00, 12'b00_00_00_00_01_00,
    12'b00_00_00_00_00_10, 12'b00_00_10_00_00_00, 12'b01_00_00_00_01_00, 12'b00_00_00_00_01_10,
    12'b00_00_00_00_00_00, 12'b00_01_01_10_00_00, 12'b00_00_10_00_00_10, 12'b00_00_10_00_00_00,
    12'b00_00_00_00_00_01, 12'b00_00_00_00_00_00, 12'b00_00_00_00_00_00, 12'b00_00_00_00_00_01};
  // {upd, z, n, v}
  localparam logic [3:0] T_FL [NV] = '{4'b1000,4'b1000,4'b1010,4'b1000,4'b1000,4'b1000,4'b1000,4'b1000,
                                       4'b1000,4'b0000,4'b0000,4'b1101,4'b1011,4'b1100,4'b1101,4'b1011,
                                       4'b1011,4'b1011,4'b1011,4'b1100,4'b1010,4'b0000,4'b0000,4'b1010};
  localparam string T_REQ [NV] = '{"R3","R3","R8","R3","R4","R4","R5","R5","R6","R10","R10","R9",
                                   "R9","R7","R4","R5","R5","R6","R7","R7","R8","R10","R10","R4"};

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [2:0] mode = '0, sel_r = '0, sel_s = '0;
  logic [6*W-1:0] reg_in = '0, reg_out;
  logic [5:0] reg_we;
  logic flag_upd, flag_z, flag_n, flag_v;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  incdec_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .sel_r(sel_r), .sel_s(sel_s),
    .reg_in(reg_in), .reg_out(reg_out), .reg_we(reg_we), .flag_upd(flag_upd),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v));

  task automatic chk(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(input int k);
    logic [95:0] exp_out;
    logic [5:0]  exp_we;
    for (int j = 0; j < 6; j++) begin
      logic [15:0] v;
      v = T_IN[k][j*16 +: 16];
      case (T_DEL[k][j*2 +: 2])
        2'b01:   begin exp_out[j*16 +: 16] = v + 16'd1; exp_we[j] = 1'b1; end
        2'b10:   begin exp_out[j*16 +: 16] = v - 16'd1; exp_we[j] = 1'b1; end
        default: begin exp_out[j*16 +: 16] = v;         exp_we[j] = 1'b0; end
      endcase
    end
    chk(T_REQ[k], $sformatf("vec%0d enables", k), {90'd0, reg_we}, {90'd0, exp_we});
    chk(T_REQ[k], $sformatf("vec%0d values R11", k), reg_out, exp_out);
    chk(T_REQ[k], $sformatf("vec%0d flags", k), {92'd0, flag_upd, flag_z, flag_n, flag_v}, {92'd0, T_FL[k]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset values", reg_out, '0);
    chk("R1", "reset enables/flags", {91'd0, reg_we[4:0] | {4'd0, reg_we[5]}, flag_upd, flag_z, flag_n, flag_v}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      go = 1'b1; mode = T_MODE[k]; sel_r = T_R[k]; sel_s = T_S[k]; reg_in = T_IN[k];
      @(negedge clk);
      check_vec(k);
    end
    // R2 idle cycle after back-to-back commands
    go = 1'b0; mode = 3'd0; sel_r = 3'd1; reg_in = IN1;
    @(negedge clk);
    chk("R2", "idle enables/flags", {89'd0, reg_we, flag_upd}, '0);
    // R2 result appears exactly one edge after go
    go = 1'b1; mode = 3'd1; sel_r = 3'd5; reg_in = IN0;
    @(negedge clk);
    go = 1'b0;
    chk("R2", "E decrement", {80'd0, reg_out[4*16 +: 16]}, {80'd0, 16'h0004});
    @(negedge clk);
    chk("R2", "single-cycle pulse", {90'd0, reg_we}, '0);
    // R1 reset after activity
    go = 1'b1; mode = 3'd0; sel_r = 3'd1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "reset clears", {reg_out[94:0], reg_we[0]} | {95'd0, flag_upd}, '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule